// File: doc/BRIEF.md
# Interrupt Redirection Table Dispatcher

This block sits between a set of interrupt input pins and a shared destination resolver. It keeps one 64-bit redirection entry per pin. Software fills the entries through a simple indexed write port and can read them back through a matching read port. When a pin is asserted, the request is held as pending until the block services it. Servicing looks up the pin's entry. A masked entry makes the block drop the request. An unmasked entry is decoded, and the block sends one request to the resolver. That request carries the vector, the destination byte, the addressing mode, the delivery-mode field and the trigger type.

Level-triggered entries set a per-pin remote-IRR status bit when they are dispatched. This bit stays set until the end-of-interrupt clear input for that pin drops it. Software cannot write the bit, but it can read it at bit 14 of the entry. When several pins are pending together, the lowest pin index is serviced first, and the block services at most one pin per cycle.

Top module: `ioapic_redir_dispatch`

## Requirements
- R1: After reset every entry reads back as 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), remote IRR is clear for all pins and `irqValid` is low.
- R2: A write with `wrEn` high and `wrIdx` below NUM_PINS (24) stores `wrData` into that pin's entry, and the new value is visible on `rdData` from the next cycle. A write whose index is NUM_PINS or more changes no entry, and reading an index of NUM_PINS or more returns zero.
- R3: When a pin is serviced while bit 16 (mask) of its entry is set, no request is issued and the pending request is discarded, so a later unmask does not revive it.
- R4: A pin asserted in cycle N with an unmasked entry and no lower pending pin raises `irqValid` for one cycle in cycle N+2. In that cycle the outputs carry `irqVector` = entry[7:0], `irqDest` = entry[63:56], `irqLogical` = entry[11] (0 physical, 1 logical), `irqDelMode` = entry[10:8], `irqLevel` = entry[15] (1 level, 0 edge) and `irqPin` = the pin index.
- R5: Pending pins are serviced in ascending pin-index order, one per cycle.
- R6: Dispatching a level-triggered entry sets that pin's remote-IRR bit, which reads back at entry bit 14 in the same cycle that `irqValid` is high. Dispatching an edge-triggered entry leaves the bit unchanged.
- R7: `eoiClear[i]` high for one cycle clears remote IRR of pin i at the next edge. If a level dispatch of pin i takes effect at that same edge, the bit ends up set.
- R8: Software writes never change entry bit 14. The value written in that position is discarded and the remote-IRR state is kept.
- R9: Asserting a pin again while it is still pending is merged into the single pending request, so the pin is dispatched once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 5 | Pin index of the entry to write |
| wrData | input | 64 | Entry value to write |
| rdIdx | input | 5 | Pin index of the entry to read |
| rdData | output | 64 | Entry value including remote IRR at bit 14 (combinational) |
| pinAssert | input | 24 | Per-pin interrupt request, one bit per pin |
| eoiClear | input | 24 | Per-pin end-of-interrupt clear of remote IRR |
| irqValid | output | 1 | One-cycle strobe: a request is issued to the resolver |
| irqVector | output | 8 | Interrupt vector |
| irqDest | output | 8 | Destination byte |
| irqLogical | output | 1 | 1 = logical addressing, 0 = physical |
| irqDelMode | output | 3 | Delivery-mode field, forwarded unchanged |
| irqLevel | output | 1 | 1 = level-triggered, 0 = edge-triggered |
| irqPin | output | 5 | Index of the pin being dispatched |

## Verification
Some properties are checked every cycle by assertions. A dispatched pin must have been pending in the previous cycle, and no lower-indexed pin may have been pending with it. Remote IRR may rise only for the pin of a level dispatch, and it must fall after an end-of-interrupt clear unless a level dispatch set it again. Other behaviour needs the bench's directed and random scenarios to show it. That covers field extraction from the stored entry, discarding requests for masked pins, merging repeated assertions, ignoring out-of-range indices, and keeping bit 14 out of software writes.

// File: rtl/rdisp_pkg.sv
package rdisp_pkg;
  localparam int ENTRY_W   = 64;
  localparam int PIN_SEL_W = 5;   // pin index width, supports up to 32 pins

  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int DMODE_LSB = 8;
  localparam int DMODE_W   = 3;
  localparam int LOGIC_BIT = 11;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam int DEST_W    = 8;

  localparam logic [ENTRY_W-1:0] RIRR_MASK   = ENTRY_W'(1) << RIRR_BIT;
  localparam logic [ENTRY_W-1:0] RESET_ENTRY = ENTRY_W'(1) << MASK_BIT;

  // control -> datapath strobes
  typedef struct packed {
    logic                 fire;
    logic [PIN_SEL_W-1:0] pin;
  } svcStrobe_t;

  // decoded request toward the destination resolver
  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DEST_W-1:0]  dest;
    logic               logical;
    logic [DMODE_W-1:0] delMode;
    logic               level;
  } irqReq_t;
endpackage

// File: rtl/rdisp_ctrl.sv
module rdisp_ctrl
  import rdisp_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinAssert,
  output svcStrobe_t          svc,
  output logic [NUM_PINS-1:0] pendVec
);
  logic                 found;
  logic [PIN_SEL_W-1:0] pick;
  logic [NUM_PINS-1:0]  clrVec;

  // lowest pending pin wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        found = 1'b1;
        pick  = PIN_SEL_W'(i);
      end
    end
  end

  assign clrVec   = found ? (NUM_PINS'(1) << pick) : '0;
  assign svc.fire = found;
  assign svc.pin  = pick;

  // new assertion wins over the clear of the pin being serviced
  always_ff @(posedge clk) begin
    if (!rstN) pendVec <= '0;
    else       pendVec <= (pendVec & ~clrVec) | pinAssert;
  end
endmodule

// File: rtl/rdisp_dpath.sv
module rdisp_dpath
  import rdisp_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [PIN_SEL_W-1:0] wrIdx,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic [PIN_SEL_W-1:0] rdIdx,
  output logic [ENTRY_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0]  eoiClear,
  input  svcStrobe_t           svc,
  output logic [NUM_PINS-1:0]  rirrVec,
  output logic                 reqValid,
  output irqReq_t              req,
  output logic [PIN_SEL_W-1:0] reqPin
);
  logic [ENTRY_W-1:0]  entryQ [NUM_PINS];
  logic [NUM_PINS-1:0] rirrQ;
  logic [NUM_PINS-1:0] wrHit;
  logic [NUM_PINS-1:0] setRirr;
  logic [NUM_PINS-1:0] pinSel;
  logic                selMask;
  irqReq_t             selReq;
  logic                svcLive;

  // per-pin decode of the write index and the serviced pin
  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    assign wrHit[g]   = wrEn && (wrIdx == PIN_SEL_W'(g));
    assign pinSel[g]  = svc.fire && (svc.pin == PIN_SEL_W'(g));
    assign setRirr[g] = pinSel[g] && svcLive && selReq.level;
  end

  // field extraction from the serviced entry
  always_comb begin
    selMask = 1'b0;
    selReq  = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pinSel[i]) begin
        selMask        = entryQ[i][MASK_BIT];
        selReq.vector  = entryQ[i][VEC_LSB +: VEC_W];
        selReq.dest    = entryQ[i][DEST_LSB +: DEST_W];
        selReq.logical = entryQ[i][LOGIC_BIT];
        selReq.delMode = entryQ[i][DMODE_LSB +: DMODE_W];
        selReq.level   = entryQ[i][TRIG_BIT];
      end
    end
  end

  assign svcLive = svc.fire && !selMask;

  // entry storage; bit 14 is never stored from software
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!rstN)         entryQ[i] <= RESET_ENTRY;
      else if (wrHit[i]) entryQ[i] <= wrData & ~RIRR_MASK;
    end
  end

  // remote IRR: a level dispatch wins over an end-of-interrupt clear
  always_ff @(posedge clk) begin
    if (!rstN) rirrQ <= '0;
    else       rirrQ <= setRirr | (rirrQ & ~eoiClear);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      req      <= '0;
      reqPin   <= '0;
    end else begin
      reqValid <= svcLive;
      req      <= selReq;
      reqPin   <= svc.pin;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rdIdx == PIN_SEL_W'(i))
        rdData = entryQ[i] | (ENTRY_W'(rirrQ[i]) << RIRR_BIT);
    end
  end

  assign rirrVec = rirrQ;
endmodule

// File: rtl/ioapic_redir_dispatch.sv
module ioapic_redir_dispatch
  import rdisp_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = PIN_SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [ENTRY_W-1:0]  wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [ENTRY_W-1:0]  rdData,
  input  logic [NUM_PINS-1:0] pinAssert,
  input  logic [NUM_PINS-1:0] eoiClear,
  output logic                irqValid,
  output logic [VEC_W-1:0]    irqVector,
  output logic [DEST_W-1:0]   irqDest,
  output logic                irqLogical,
  output logic [DMODE_W-1:0]  irqDelMode,
  output logic                irqLevel,
  output logic [IDX_W-1:0]    irqPin
);
  svcStrobe_t          svc;
  logic [NUM_PINS-1:0] pendVec;
  logic [NUM_PINS-1:0] rirrVec;
  irqReq_t             req;

  rdisp_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pinAssert(pinAssert),
    .svc      (svc),
    .pendVec  (pendVec)
  );

  rdisp_dpath #(.NUM_PINS(NUM_PINS)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .eoiClear(eoiClear),
    .svc     (svc),
    .rirrVec (rirrVec),
    .reqValid(irqValid),
    .req     (req),
    .reqPin  (irqPin)
  );

  assign irqVector  = req.vector;
  assign irqDest    = req.dest;
  assign irqLogical = req.logical;
  assign irqDelMode = req.delMode;
  assign irqLevel   = req.level;
endmodule

// File: rtl/ioapic_redir_dispatch_chk.sv
module ioapic_redir_dispatch_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                irqValid,
  input logic                irqLevel,
  input logic [IDX_W-1:0]    irqPin,
  input logic [NUM_PINS-1:0] pendVec,
  input logic [NUM_PINS-1:0] rirrVec,
  input logic [NUM_PINS-1:0] eoiClear
);
  logic [NUM_PINS-1:0] pinBit;
  logic [NUM_PINS-1:0] levelBit;

  assign pinBit   = NUM_PINS'(1) << irqPin;
  assign levelBit = (irqValid && irqLevel) ? pinBit : '0;

  AST_PIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (int'(irqPin) < NUM_PINS)); // R4

  AST_FROM_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (($past(pendVec) & pinBit) != '0)); // R4

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (($past(pendVec) & (pinBit - NUM_PINS'(1))) == '0)); // R5

  AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqLevel) |-> ((rirrVec & pinBit) != '0)); // R6

  AST_RIRR_RISE_ONLY_ON_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    ((rirrVec & ~$past(rirrVec)) != '0) |-> (irqValid && irqLevel && ((rirrVec & ~$past(rirrVec)) == pinBit))); // R6

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((rirrVec & $past(eoiClear) & ~levelBit) == '0)); // R7
endmodule

bind ioapic_redir_dispatch ioapic_redir_dispatch_chk #(
  .NUM_PINS(NUM_PINS),
  .IDX_W   (IDX_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .irqValid(irqValid),
  .irqLevel(irqLevel),
  .irqPin  (irqPin),
  .pendVec (pendVec),
  .rirrVec (rirrVec),
  .eoiClear(eoiClear)
);

// File: tb/tb_ioapic_redir_dispatch.sv
module tb_ioapic_redir_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [IW-1:0] wrIdx;
  logic [63:0]   wrData;
  logic [IW-1:0] rdIdx;
  logic [63:0]   rdData;
  logic [NP-1:0] pinAssert;
  logic [NP-1:0] eoiClear;
  logic          irqValid;
  logic [7:0]    irqVector;
  logic [7:0]    irqDest;
  logic          irqLogical;
  logic [2:0]    irqDelMode;
  logic          irqLevel;
  logic [IW-1:0] irqPin;

  ioapic_redir_dispatch #(.NUM_PINS(NP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .pinAssert(pinAssert), .eoiClear(eoiClear),
    .irqValid(irqValid), .irqVector(irqVector), .irqDest(irqDest),
    .irqLogical(irqLogical), .irqDelMode(irqDelMode), .irqLevel(irqLevel),
    .irqPin(irqPin)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // reference model state
  logic [63:0]   mTab [NP];
  logic [NP-1:0] mRirr, mPend;
  logic          eValid;
  logic [7:0]    eVec, eDest;
  logic          eLog, eLvl;
  logic [2:0]    eDel;
  logic [IW-1:0] ePin;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRd(logic [IW-1:0] idx);
    if (int'(idx) >= NP) return 64'h0;
    return mTab[idx] | (64'(mRirr[idx]) << 14);
  endfunction

  task automatic modelStep();
    int pick = -1;
    logic [NP-1:0] setV = '0;
    for (int i = 0; i < NP; i++) if (mPend[i] && pick < 0) pick = i;
    eValid = 1'b0;
    if (pick >= 0) begin
      if (!mTab[pick][16]) begin
        eValid = 1'b1;
        eVec   = mTab[pick][7:0];
        eDest  = mTab[pick][63:56];
        eLog   = mTab[pick][11];
        eDel   = mTab[pick][10:8];
        eLvl   = mTab[pick][15];
        ePin   = IW'(pick);
        if (mTab[pick][15]) setV[pick] = 1'b1;
      end
      mPend[pick] = 1'b0;
    end
    mRirr = setV | (mRirr & ~eoiClear);
    if (wrEn && int'(wrIdx) < NP) mTab[wrIdx] = wrData & ~(64'h1 << 14);
    mPend = mPend | pinAssert;
  endtask

  // apply current inputs across one edge, then compare against the model
  task automatic doCycle();
    modelStep();
    @(negedge clk);
    chk("R4 irqValid", 64'(irqValid), 64'(eValid));
    if (eValid && irqValid) begin
      chk("R4 vector", 64'(irqVector), 64'(eVec));
      chk("R4 dest", 64'(irqDest), 64'(eDest));
      chk("R4 logical", 64'(irqLogical), 64'(eLog));
      chk("R4 delmode", 64'(irqDelMode), 64'(eDel));
      chk("R4 level", 64'(irqLevel), 64'(eLvl));
      chk("R5 pin order", 64'(irqPin), 64'(ePin));
    end
    chk("R2 readback", rdData, expRd(rdIdx));
  endtask

  task automatic idle();
    wrEn = 1'b0; pinAssert = '0; eoiClear = '0;
  endtask

  task automatic writeEntry(int idx, logic [63:0] val);
    wrEn = 1'b1; wrIdx = IW'(idx); wrData = val;
    doCycle();
    idle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; wrIdx = '0; wrData = '0; rdIdx = '0; idle();
    for (int i = 0; i < NP; i++) mTab[i] = 64'h0000_0000_0001_0000;
    mRirr = '0; mPend = '0; eValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 irqValid after reset", 64'(irqValid), 64'h0);
    for (int i = 0; i < NP; i++) begin
      rdIdx = IW'(i); #1;
      chk("R1 reset entry", rdData, 64'h0000_0000_0001_0000);
    end

    // R8 / R2: write with bit 14 set, level logical delmode 1 vector 0x41 dest 0x5A
    rdIdx = 5'd3;
    writeEntry(3, 64'h5A00_0000_0000_C941);
    chk("R8 bit14 not writable", rdData, 64'h5A00_0000_0000_8941);

    // R4 / R6: dispatch pin 3, two cycles of latency
    pinAssert = NP'(1) << 3; doCycle(); idle();
    chk("R4 no output one cycle after assert", 64'(irqValid), 64'h0);
    doCycle();
    chk("R4 valid two cycles after assert", 64'(irqValid), 64'h1);
    chk("R4 vector field", 64'(irqVector), 64'h41);
    chk("R4 dest field", 64'(irqDest), 64'h5A);
    chk("R4 logical mode", 64'(irqLogical), 64'h1);
    chk("R4 delivery mode", 64'(irqDelMode), 64'h1);
    chk("R4 level trigger", 64'(irqLevel), 64'h1);
    chk("R4 pin index", 64'(irqPin), 64'd3);
    chk("R6 remote IRR set", rdData, 64'h5A00_0000_0000_C941);

    // R7: clear via end of interrupt
    eoiClear = NP'(1) << 3; doCycle(); idle();
    chk("R7 eoi clears remote IRR", rdData, 64'h5A00_0000_0000_8941);

    // R7: dispatch and clear at the same edge, set wins
    pinAssert = NP'(1) << 3; doCycle(); idle();
    eoiClear = NP'(1) << 3; doCycle(); idle();
    chk("R7 set wins over clear", rdData, 64'h5A00_0000_0000_C941);
    eoiClear = NP'(1) << 3; doCycle(); idle();

    // R5 / R9 / R6: pins 2 and 5 edge-triggered, asserted together
    writeEntry(2, 64'h1100_0000_0000_0022);
    writeEntry(5, 64'h2200_0000_0000_0355);
    rdIdx = 5'd2;
    pinAssert = (NP'(1) << 2) | (NP'(1) << 5); doCycle(); idle();
    pinAssert = NP'(1) << 5; doCycle(); idle();
    chk("R5 lowest pin first", 64'(irqPin), 64'd2);
    chk("R6 edge leaves remote IRR clear", rdData, 64'h1100_0000_0000_0022);
    doCycle();
    chk("R5 next pin second", 64'(irqPin), 64'd5);
    chk("R5 next pin valid", 64'(irqValid), 64'h1);
    chk("R4 delivery mode passed", 64'(irqDelMode), 64'h3);
    doCycle();
    chk("R9 repeated assert merged", 64'(irqValid), 64'h0);

    // R3: masked pin 7 is dropped and not revived by unmask
    pinAssert = NP'(1) << 7; doCycle(); idle();
    doCycle();
    chk("R3 masked pin suppressed", 64'(irqValid), 64'h0);
    writeEntry(7, 64'h0000_0000_0000_0077);
    doCycle();
    chk("R3 dropped request stays dropped", 64'(irqValid), 64'h0);

    // R2: out-of-range index
    rdIdx = 5'd24;
    writeEntry(24, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 out-of-range read is zero", rdData, 64'h0);
    for (int i = 0; i < NP; i++) begin
      rdIdx = IW'(i); #1;
      chk("R2 out-of-range write ignored", rdData, expRd(IW'(i)));
    end

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      pinAssert = NP'($urandom & $urandom & $urandom);
      eoiClear  = NP'($urandom & $urandom);
      wrEn      = ($urandom % 4) == 0;
      wrIdx     = IW'($urandom % 32);
      wrData    = {$urandom, $urandom};
      rdIdx     = IW'($urandom % 32);
      doCycle();
    end
    idle();
    repeat (NP + 2) doCycle();
    for (int i = 0; i < NP; i++) begin
      rdIdx = IW'(i); #1;
      chk("R2 final table contents", rdData, expRd(IW'(i)));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule